// File: doc/BRIEF.md
# Split 64-bit Shift-and-Add Pair

This block adds two 64-bit quantities and shifts the second one left by a small immediate (0 to 7) before the add. The work is split across two 32-bit adder slices. The low slice adds the low word of the first operand to the shifted low word of the second operand. It then hands the high slice a private link that carries five things: the carry out, the bits shifted out of the low word, the shift amount, the mode and an extension fill bit. The high slice uses this link to finish the upper word. Because the link is not a regular operand, both slices are always issued in the same cycle.

Three operand modes are supported. In the full mode the second operand is a true 64-bit value. In the two extension modes the second operand is a 32-bit value that is widened to 64 bits before the shift, with zeros or with copies of its sign bit, and the high word of the second operand is not used. A typical use is stepping a 64-bit pointer by a scaled 32-bit or 64-bit index.

The operands come from registers upstream. The slices are pure logic, and the 64-bit result is registered at the block's output.

Top module: `shadd_pair`

## Requirements
- R1: With mode = 0 (full), the result one cycle after issue equals {a_hi,a_lo} + ({b_hi,b_lo} << shamt), truncated to 64 bits.
- R2: With mode = 1 (zero-extend), the result equals {a_hi,a_lo} + ({32'b0,b_lo} << shamt), truncated to 64 bits.
- R3: With mode = 2 (sign-extend), the result equals {a_hi,a_lo} + ({{32{b_lo[31]}},b_lo} << shamt), truncated to 64 bits.
- R4: In modes 1 and 2 the value on b_hi has no effect on the result.
- R5: The shift amount shamt (0 to 7) scales only the second operand. The first operand is never shifted.
- R6: In every valid mode, result[31:0] equals the low 32 bits of a_lo + (b_lo << shamt).
- R7: result_valid is high exactly in the cycle after a cycle with issue high. result and result_err keep their values while issue is low.
- R8: Mode 3 is reserved. An issue with mode 3 gives result = 0 and result_err = 1.
- R9: An issue with modes 0, 1 or 2 gives result_err = 0.
- R10: After reset, result_valid, result_err and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Issue strobe that starts both slices together |
| mode | input | 2 | 0 full, 1 zero-extend, 2 sign-extend, 3 reserved |
| shamt | input | 3 | Left shift applied to the second operand |
| a_lo | input | 32 | First operand, low word |
| a_hi | input | 32 | First operand, high word |
| b_lo | input | 32 | Second operand, low word (the whole operand in the extension modes) |
| b_hi | input | 32 | Second operand, high word (not used in the extension modes) |
| result_valid | output | 1 | High one cycle after issue |
| result | output | 64 | Registered 64-bit sum |
| result_err | output | 1 | Reserved mode was issued |

## Verification
The link between the slices is the only internal state, and an error in it shows up only in the upper word of the registered result. The output appears one cycle after the issue. A dropped carry makes the high word one too small. A wrong spill makes it differ in its low shamt bits. A wrong fill bit appears only in sign-extend mode with a negative b_lo. The bench sweeps every shift and every mode against edge patterns and pseudo-random words, so each of these faults reaches result on the first affected issue.

// File: rtl/shadd_pkg.sv
package shadd_pkg;

  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_ZEXT = 2'd1,
    MODE_SEXT = 2'd2,
    MODE_RSVD = 2'd3
  } shadd_mode_e;

endpackage

// File: rtl/shadd_lo_slice.sv
module shadd_lo_slice
  import shadd_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = 3,
  localparam int SPILL_W = (1 << SHIFT_W) - 1
) (
  input  logic [WORD_W-1:0]  a_lo,
  input  logic [WORD_W-1:0]  b_lo,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic [1:0]         mode,
  output logic [WORD_W-1:0]  sum_lo,
  output logic               link_carry,
  output logic               link_fill,
  output logic [SPILL_W-1:0] link_spill,
  output logic [SHIFT_W-1:0] link_shamt,
  output logic [1:0]         link_mode
);

  localparam int WIDE_W = WORD_W + SPILL_W;

  logic [WIDE_W-1:0]  wide;
  logic [WORD_W:0]    sum_ext;

  // Bits leaving the low word land in the spill field, right-aligned.
  always_comb begin
    wide    = {{SPILL_W{1'b0}}, b_lo} << shamt;
    sum_ext = {1'b0, a_lo} + {1'b0, wide[WORD_W-1:0]};
  end

  assign sum_lo     = sum_ext[WORD_W-1:0];
  assign link_carry = sum_ext[WORD_W];
  assign link_spill = wide[WIDE_W-1:WORD_W];
  assign link_fill  = (shadd_mode_e'(mode) == MODE_SEXT) && b_lo[WORD_W-1];
  assign link_shamt = shamt;
  assign link_mode  = mode;

endmodule

// File: rtl/shadd_hi_slice.sv
module shadd_hi_slice
  import shadd_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = 3,
  localparam int SPILL_W = (1 << SHIFT_W) - 1
) (
  input  logic [WORD_W-1:0]  a_hi,
  input  logic [WORD_W-1:0]  b_hi,
  input  logic               link_carry,
  input  logic               link_fill,
  input  logic [SPILL_W-1:0] link_spill,
  input  logic [SHIFT_W-1:0] link_shamt,
  input  logic [1:0]         link_mode,
  output logic [WORD_W-1:0]  sum_hi,
  output logic               bad_mode
);

  logic [WORD_W-1:0] src_word;
  logic [WORD_W-1:0] operand;

  // The extension modes replace b_hi with a synthesized extension word.
  always_comb begin
    unique case (shadd_mode_e'(link_mode))
      MODE_FULL: src_word = b_hi;
      MODE_ZEXT: src_word = '0;
      MODE_SEXT: src_word = {WORD_W{link_fill}};
      default:   src_word = '0;
    endcase
    operand = (src_word << link_shamt)
            | {{(WORD_W-SPILL_W){1'b0}}, link_spill};
  end

  assign sum_hi   = a_hi + operand + {{(WORD_W-1){1'b0}}, link_carry};
  assign bad_mode = (shadd_mode_e'(link_mode) == MODE_RSVD);

endmodule

// File: rtl/shadd_out_reg.sv
module shadd_out_reg #(
  parameter int RES_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] next_result,
  input  logic             next_err,
  output logic             result_valid,
  output logic [RES_W-1:0] result,
  output logic             result_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid <= 1'b0;
      result       <= '0;
      result_err   <= 1'b0;
    end else begin
      result_valid <= load;
      if (load) begin
        result     <= next_err ? '0 : next_result;
        result_err <= next_err;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(result) && $stable(result_err)); // R7

endmodule

// File: rtl/shadd_pair.sv
module shadd_pair
  import shadd_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = 3,
  localparam int SPILL_W = (1 << SHIFT_W) - 1,
  localparam int RES_W   = 2 * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue,
  input  logic [1:0]         mode,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic [WORD_W-1:0]  a_lo,
  input  logic [WORD_W-1:0]  a_hi,
  input  logic [WORD_W-1:0]  b_lo,
  input  logic [WORD_W-1:0]  b_hi,
  output logic               result_valid,
  output logic [RES_W-1:0]   result,
  output logic               result_err
);

  logic [WORD_W-1:0]  sum_lo;
  logic [WORD_W-1:0]  sum_hi;
  logic               lk_carry;
  logic               lk_fill;
  logic [SPILL_W-1:0] lk_spill;
  logic [SHIFT_W-1:0] lk_shamt;
  logic [1:0]         lk_mode;
  logic               bad_mode;

  shadd_lo_slice #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) i_lo (
    .a_lo(a_lo), .b_lo(b_lo), .shamt(shamt), .mode(mode),
    .sum_lo(sum_lo), .link_carry(lk_carry), .link_fill(lk_fill),
    .link_spill(lk_spill), .link_shamt(lk_shamt), .link_mode(lk_mode)
  );

  shadd_hi_slice #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) i_hi (
    .a_hi(a_hi), .b_hi(b_hi), .link_carry(lk_carry), .link_fill(lk_fill),
    .link_spill(lk_spill), .link_shamt(lk_shamt), .link_mode(lk_mode),
    .sum_hi(sum_hi), .bad_mode(bad_mode)
  );

  shadd_out_reg #(.RES_W(RES_W)) i_out (
    .clk(clk), .rst(rst), .load(issue),
    .next_result({sum_hi, sum_lo}), .next_err(bad_mode),
    .result_valid(result_valid), .result(result), .result_err(result_err)
  );

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    issue |=> result_valid); // R7
  AST_VALID_ONLY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    !issue |=> !result_valid); // R7
  AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    issue && (mode == 2'd3) |=> result_err && (result == '0)); // R8
  AST_GOOD_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    issue && (mode != 2'd3) |=> !result_err); // R9
  AST_LOW_WORD: assert property (@(posedge clk) disable iff (rst)
    issue && (mode != 2'd3)
    |=> result[WORD_W-1:0] == $past(a_lo + (b_lo << shamt))); // R6

endmodule

// File: tb/test_shadd_pair.sv
module test_shadd_pair;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue;
  logic [1:0]  mode;
  logic [2:0]  shamt;
  logic [31:0] a_lo, a_hi, b_lo, b_hi;
  logic        result_valid;
  logic [63:0] result;
  logic        result_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  shadd_pair i_shadd_pair (
    .clk(clk), .rst(rst), .issue(issue), .mode(mode), .shamt(shamt),
    .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
    .result_valid(result_valid), .result(result), .result_err(result_err)
  );

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    case (k)
      0: pat = 32'h0000_0000;
      1: pat = 32'hFFFF_FFFF;
      2: pat = 32'h8000_0000;
      3: pat = 32'h7FFF_FFFF;
      4: pat = 32'hFE00_0001;
      default: pat = (k * 32'h9E37_79B9) ^ (32'h5A5A_1234 >> (k % 13));
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [1:0] m, input logic [2:0] s,
      input logic [31:0] al, input logic [31:0] ah, input logic [31:0] bl, input logic [31:0] bh);
    logic [63:0] bx;
    case (m)
      2'd0: bx = {bh, bl};
      2'd1: bx = {32'b0, bl};
      default: bx = {{32{bl[31]}}, bl};
    endcase
    model = {ah, al} + (bx << s);
  endfunction

  task automatic run_op(input logic [1:0] m, input logic [2:0] s,
      input logic [31:0] al, input logic [31:0] ah, input logic [31:0] bl, input logic [31:0] bh);
    @(negedge clk);
    issue = 1'b1; mode = m; shamt = s; a_lo = al; a_hi = ah; b_lo = bl; b_hi = bh;
    @(negedge clk);
    issue = 1'b0;
    chk64("R7 valid", {63'b0, result_valid}, 64'd1);
    if (m == 2'd3) begin
      chk64("R8 result", result, 64'd0);
      chk64("R8 err", {63'b0, result_err}, 64'd1);
    end else begin
      case (m)
        2'd0: chk64("R1 full", result, model(m, s, al, ah, bl, bh));
        2'd1: chk64("R2 zext", result, model(m, s, al, ah, bl, bh));
        default: chk64("R3 sext", result, model(m, s, al, ah, bl, bh));
      endcase
      chk64("R6 low", {32'b0, result[31:0]}, {32'b0, al + (bl << s)});
      chk64("R9 err", {63'b0, result_err}, 64'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst = 1'b1; issue = 1'b0; mode = 2'd0; shamt = 3'd0;
    a_lo = '0; a_hi = '0; b_lo = '0; b_hi = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk64("R10 valid", {63'b0, result_valid}, 64'd0);
    chk64("R10 result", result, 64'd0);
    chk64("R10 err", {63'b0, result_err}, 64'd0);

    // Sweep over mode, shift and operand patterns (R1, R2, R3, R5, R6, R8, R9)
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 10; k++)
          run_op(m[1:0], s[2:0], pat(k), pat(k + 3), pat(9 - k), pat(k + 7));

    // R5: first operand is not shifted; a = 1, b = 0, shift 7
    run_op(2'd0, 3'd7, 32'd1, 32'd0, 32'd0, 32'd0);
    chk64("R5 a unshifted", result, 64'd1);

    // R4: b_hi ignored in extension modes
    for (int m = 1; m < 3; m++)
      for (int s = 0; s < 8; s++) begin
        run_op(m[1:0], s[2:0], 32'hDEAD_BEEF, 32'h0123_4567, 32'h9000_0003, 32'h0000_0000);
        held = result;
        run_op(m[1:0], s[2:0], 32'hDEAD_BEEF, 32'h0123_4567, 32'h9000_0003, 32'hFFFF_FFFF);
        chk64("R4 b_hi ignored", result, held);
      end

    // R7: idle cycles keep result and drop valid
    run_op(2'd0, 3'd3, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444);
    held = result;
    mode = 2'd3; a_lo = 32'hFFFF_FFFF;
    @(negedge clk);
    chk64("R7 valid drop", {63'b0, result_valid}, 64'd0);
    chk64("R7 hold", result, held);
    chk64("R7 err hold", {63'b0, result_err}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule